// File: doc/BRIEF.md
# Sleep and Wake-Event Controller

This block holds the low-power wait state of a small processor core. The core raises either a wait-for-interrupt request or a wait-for-event request. The block then decides whether the core sleeps, and it later decides when the core is released. A one-bit sticky event flag records events that arrive while the core is running. A later wait-for-event consumes that flag and returns at once, so the event is not lost.

Interrupt eligibility arrives already resolved, one bit per line. The inputs are a pending bit, an enable bit and a bit meaning "not blocked by the current priority". A separate input carries the global interrupt mask. The two kinds of wait react to different wake sources. Wait-for-interrupt also wakes on an interrupt that would be taken except for the global mask. Wait-for-event instead wakes on events, and it wakes on newly pending interrupts when the pending-wake enable is set. Clock gating, priority arbitration and exception entry are handled outside this block.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While reset is held and after it is released, `sleeping`, `wake` and `event_flag` are all 0.
- R2: When `sev_pulse` or `ext_event` is 1 and the core is not in a wait-for-event sleep and no wait-for-event is accepted in that cycle, `event_flag` is 1 after the next clock edge.
- R3: A wait-for-event accepted while `event_flag` is 1 does not sleep. On the next edge it clears `event_flag` to 0 and pulses `wake`.
- R4: A wait-for-event accepted with `event_flag` 0 and no wake source true sets `sleeping` on the next edge.
- R5: An interrupt line counts as eligible when it is pending, enabled and priority-permitted. An eligible line with `global_mask` 0 wakes either sleep. An eligible line with `global_mask` 1 does not wake a wait-for-event sleep.
- R6: In a wait-for-event sleep, a 0-to-1 change of any `irq_pending` bit (compared with the previous cycle) wakes the core only when `pend_wake_en` is 1. This holds whether or not the line is enabled.
- R7: `dbg_req` wakes a wait-for-interrupt sleep unconditionally. It wakes a wait-for-event sleep only when `dbg_en` is 1.
- R8: `sev_pulse` or `ext_event` wakes a wait-for-event sleep, and the event is absorbed: `event_flag` stays 0.
- R9: A wait-for-interrupt sleep wakes on any eligible line whatever the value of `global_mask`. Events do not wake it; they set `event_flag` instead.
- R10: When a sleeping core sees its wake condition, `sleeping` clears after the next edge. `wake` is 1 for exactly that one cycle.
- R11: A wait request whose wake condition is already true when it is accepted does not sleep. `wake` pulses on the next edge.
- R12: Wait requests are ignored while sleeping. When both requests arrive together, wait-for-interrupt takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_req | input | 1 | Wait-for-interrupt request, one cycle |
| wfe_req | input | 1 | Wait-for-event request, one cycle |
| sev_pulse | input | 1 | Send-event signal from a core |
| ext_event | input | 1 | Event from a peripheral |
| irq_pending | input | NIRQ | Per-line pending status |
| irq_enable | input | NIRQ | Per-line enable |
| irq_prio_ok | input | NIRQ | Per-line: not blocked by current priority |
| global_mask | input | 1 | Global interrupt mask |
| pend_wake_en | input | 1 | Newly pending interrupt wakes wait-for-event |
| dbg_req | input | 1 | Debug entry request |
| dbg_en | input | 1 | Debug enabled |
| sleeping | output | 1 | Core is in a wait state |
| wake | output | 1 | One-cycle release pulse |
| event_flag | output | 1 | Sticky event register |

## Verification
Every result of this block appears one clock edge after the stimulus that causes it. This covers sleep entry, release from sleep, the immediate-return pulse and the event flag update. The bench drives inputs on the falling edge and samples on the next falling edge, so each check sees exactly one rising edge between cause and effect. The bench also checks that the wake pulse has dropped one edge later. Between trials, the bench holds every input low for a cycle, so each newly pending interrupt is a clean rise from 0.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wfi_req,
  input  logic            wfe_req,
  input  logic            sev_pulse,
  input  logic            ext_event,
  input  logic [NIRQ-1:0] irq_pending,
  input  logic [NIRQ-1:0] irq_enable,
  input  logic [NIRQ-1:0] irq_prio_ok,
  input  logic            global_mask,
  input  logic            pend_wake_en,
  input  logic            dbg_req,
  input  logic            dbg_en,
  output logic            sleeping,
  output logic            wake,
  output logic            event_flag
);

  typedef enum logic [1:0] {ST_RUN, ST_WFI, ST_WFE} st_t;

  st_t             st;
  logic [NIRQ-1:0] pend_q;
  logic            elig, taken, pend_rise, any_evt;
  logic            wfi_hit, wfe_hit, run, take_wfi, take_wfe;

  assign elig      = |(irq_pending & irq_enable & irq_prio_ok);
  assign taken     = elig & ~global_mask;
  assign pend_rise = |(irq_pending & ~pend_q);
  assign any_evt   = sev_pulse | ext_event;
  assign wfi_hit   = elig | dbg_req;
  assign wfe_hit   = taken | (pend_wake_en & pend_rise) | (dbg_req & dbg_en) | any_evt;
  assign run       = (st == ST_RUN);
  assign take_wfi  = run & wfi_req;
  assign take_wfe  = run & wfe_req & ~wfi_req;
  assign sleeping  = ~run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_RUN;
      wake       <= 1'b0;
      event_flag <= 1'b0;
      pend_q     <= '0;
    end else begin
      pend_q <= irq_pending;
      wake   <= 1'b0;
      case (st)
        ST_RUN: begin
          if (take_wfi) begin
            if (wfi_hit) wake <= 1'b1;
            else         st   <= ST_WFI;
          end else if (take_wfe) begin
            if (event_flag || wfe_hit) wake <= 1'b1;
            else                       st   <= ST_WFE;
          end
        end
        ST_WFI: if (wfi_hit) begin st <= ST_RUN; wake <= 1'b1; end
        ST_WFE: if (wfe_hit) begin st <= ST_RUN; wake <= 1'b1; end
        default: st <= ST_RUN;
      endcase
      if (take_wfe)                        event_flag <= 1'b0;
      else if (any_evt && st != ST_WFE)    event_flag <= 1'b1;
    end
  end

  p_evt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && any_evt && !take_wfe) |=> event_flag);

  p_wfe_quick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_wfe && event_flag) |=> (!sleeping && wake && !event_flag));

  p_wfe_absorb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WFE) |=> !event_flag);

  p_wfi_events_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WFI && !wfi_hit) |=> sleeping);

  p_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WFI && wfi_hit) || (st == ST_WFE && wfe_hit)) |=> (!sleeping && wake));

  p_wake_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !sleeping);

  p_prio_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wfi_req && wfe_req && !wfi_hit) |=> (st == ST_WFI));

endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
  localparam int N = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wfi_req, wfe_req, sev_pulse, ext_event, global_mask, pend_wake_en, dbg_req, dbg_en;
  logic [N-1:0] irq_pending, irq_enable, irq_prio_ok;
  logic sleeping, wake, event_flag;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.NIRQ(N)) i_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .sev_pulse(sev_pulse), .ext_event(ext_event), .irq_pending(irq_pending),
    .irq_enable(irq_enable), .irq_prio_ok(irq_prio_ok), .global_mask(global_mask),
    .pend_wake_en(pend_wake_en), .dbg_req(dbg_req), .dbg_en(dbg_en),
    .sleeping(sleeping), .wake(wake), .event_flag(event_flag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_all();
    wfi_req = 0; wfe_req = 0; sev_pulse = 0; ext_event = 0; global_mask = 0;
    pend_wake_en = 0; dbg_req = 0; dbg_en = 0;
    irq_pending = '0; irq_enable = '0; irq_prio_ok = '0;
  endtask

  task automatic state_chk(input string req, input bit s, input bit w, input bit e);
    chk(sleeping == s, {req, " sleeping"}, sleeping, s);
    chk(wake == w, {req, " wake"}, wake, w);
    chk(event_flag == e, {req, " event_flag"}, event_flag, e);
  endtask

  task automatic trial(input bit is_wfi, input logic [N-1:0] p, input logic [N-1:0] e,
                       input logic [N-1:0] o, input bit g, input bit pwe, input bit dr,
                       input bit de, input bit ex, input bit exp_wake, input string req);
    @(negedge clk); clear_all(); wfi_req = is_wfi; wfe_req = !is_wfi;
    @(negedge clk); clear_all();
    state_chk(is_wfi ? "R9 entry" : "R4 entry", 1, 0, 0);
    irq_pending = p; irq_enable = e; irq_prio_ok = o; global_mask = g;
    pend_wake_en = pwe; dbg_req = dr; dbg_en = de; ext_event = ex;
    @(negedge clk);
    state_chk(req, !exp_wake, exp_wake, 0);
    clear_all();
    if (sleeping) begin
      if (is_wfi) dbg_req = 1; else ext_event = 1;
      @(negedge clk); clear_all();
    end
    @(negedge clk);
    state_chk("R10 pulse end", 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    state_chk("R1 in reset", 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    state_chk("R1 after reset", 0, 0, 0);

    for (int c = 0; c < 64; c++)
      for (int g = 0; g < 2; g++)
        trial(1, c[1:0], c[3:2], c[5:4], g[0], 0, 0, 0, 0,
              |(c[1:0] & c[3:2] & c[5:4]), "R5 R9 wfi irq");

    for (int c = 0; c < 64; c++)
      for (int m = 0; m < 4; m++)
        trial(0, c[1:0], c[3:2], c[5:4], m[0], m[1], 0, 0, 0,
              (|(c[1:0] & c[3:2] & c[5:4]) & !m[0]) | (m[1] & |c[1:0]), "R5 R6 wfe irq");

    for (int m = 0; m < 4; m++) begin
      trial(1, '0, '0, '0, 0, 0, m[0], m[1], 0, m[0], "R7 wfi dbg");
      trial(0, '0, '0, '0, 0, 0, m[0], m[1], 0, m[0] & m[1], "R7 wfe dbg");
    end

    trial(0, '0, '0, '0, 0, 0, 0, 0, 1, 1, "R8 wfe ext_event");
    @(negedge clk); wfe_req = 1;
    @(negedge clk); wfe_req = 0;
    state_chk("R4 entry", 1, 0, 0);
    sev_pulse = 1;
    @(negedge clk); sev_pulse = 0;
    state_chk("R8 wfe sev", 0, 1, 0);

    @(negedge clk); wfi_req = 1;
    @(negedge clk); wfi_req = 0;
    state_chk("R9 entry", 1, 0, 0);
    sev_pulse = 1; wfe_req = 1;
    @(negedge clk); sev_pulse = 0; wfe_req = 0;
    state_chk("R9 R12 event in wfi", 1, 0, 1);
    dbg_req = 1;
    @(negedge clk); dbg_req = 0;
    state_chk("R10 wfi wake", 0, 1, 1);
    @(negedge clk);
    state_chk("R10 one cycle", 0, 0, 1);

    wfe_req = 1;
    @(negedge clk); wfe_req = 0;
    state_chk("R3 quick return", 0, 1, 0);

    ext_event = 1;
    @(negedge clk); ext_event = 0;
    state_chk("R2 event set", 0, 0, 1);
    wfi_req = 1; wfe_req = 1;
    @(negedge clk); wfi_req = 0; wfe_req = 0;
    state_chk("R12 wfi priority", 1, 0, 1);
    dbg_req = 1;
    @(negedge clk); dbg_req = 0;
    @(negedge clk);
    wfe_req = 1;
    @(negedge clk); wfe_req = 0;
    state_chk("R3 consume", 0, 1, 0);

    @(negedge clk);
    wfi_req = 1; dbg_req = 1;
    @(negedge clk); wfi_req = 0; dbg_req = 0;
    state_chk("R11 wfi already", 0, 1, 0);
    @(negedge clk);
    wfe_req = 1; irq_pending = 2'b01; irq_enable = 2'b01; irq_prio_ok = 2'b01;
    @(negedge clk); clear_all();
    state_chk("R11 wfe already", 0, 1, 0);
    @(negedge clk);
    state_chk("R10 end", 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule